// File: doc/BRIEF.md
# Timer Counter Time Base

This block is the counting core of a general-purpose timer. A prescaler divides the clock into counting ticks. A 16-bit counter steps once per tick between zero and an auto-reload limit. It can count up, count down, or run in a triangle (centre-aligned) pattern in one of three variants. Each wrap of the counter is a candidate update. An 8-bit repetition counter lets only every (N+1)th candidate through as a real update event. At an update event the staged prescaler, reload and repetition values are copied into the working registers.

Software or a slave trigger can force an update at any time. A forced update also restarts the counter and the prescaler. An update-disable control blocks every update event. An update-source control decides whether forced updates set the sticky update flag. In one-shot mode the counter stops at the first hardware update event. The host reads the counter value and the current counting direction. It sees one-cycle update pulses and the sticky flag, and clears the flag with a strobe.

Top module: `tmr_timebase`

## Requirements
- R1: After a synchronous active-low reset, `cnt_out` is 0, `cnt_dir` is 0 (up, edge mode, `dir_down`=0), `upd_pulse` is 0 and `upd_flag` is 0. The working reload limit resets to all ones and the working prescaler to 0.
- R2: While running (`cnt_en`=1 and not halted), the counter takes one step every P+1 clock cycles, where P is the working prescaler value. While not running, both the counter and the prescaler count hold their values.
- R3: With `align_mode`=0 and `dir_down`=0, the counter steps 0,1,…,L and then returns to 0, where L is the working reload limit. Each return to 0 is a wrap. A counter already above L also wraps to 0 on its next step.
- R4: With `align_mode`=0 and `dir_down`=1, the counter steps down to 0. On its next step it reloads L, and that reload is a wrap. `cnt_dir` equals `dir_down` in this mode.
- R5: With `align_mode` of 1, 2 or 3, the counter runs 0 up to L and then back down to 0, repeatedly. `cnt_dir` is 1 while the counter is descending. The step at the top turns the count downward and is a wrap only in modes 2 and 3. The step at the bottom turns the count upward and is a wrap only in modes 1 and 3. With L=0 the counter stays at 0.
- R6: An update event comes from a wrap only when the repetition count is 0. At each update event the repetition count reloads `rep_val`. A wrap with a non-zero repetition count decrements that count instead.
- R7: With `psc_now`=1, `psc_val` becomes the working prescaler on the next clock edge. With `psc_now`=0, it is loaded only at an update event.
- R8: With `arl_buf_en`=0, `arl_val` becomes the working reload limit on the next clock edge. With `arl_buf_en`=1, it is loaded only at an update event.
- R9: While `upd_dis`=1, no update event occurs. There is then no pulse, no flag set, no staged-value load and no repetition reload. Counting, wrapping and restart still happen.
- R10: A hardware update event always sets `upd_flag`. A forced update (`sw_upd` or `slv_trig`) sets it only when `upd_src_all`=1.
- R11: `upd_flag` stays set until `flag_clr` is high on a clock edge with no new flag-setting event. If both happen on the same edge, the set takes priority.
- R12: With `one_shot`=1, a hardware update event halts counting, with the counter left at its wrapped value. Counting stays halted until `cnt_en` is driven low.
- R13: `sw_upd` or `slv_trig` clears the counter and the prescaler count and turns the centre-mode direction upward. It does this even while not running, and it is also an update event unless `upd_dis`=1.
- R14: `upd_pulse` is high for exactly the one cycle that follows each clock edge on which an update event occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counting enable; low also releases a one-shot halt |
| upd_dis | input | 1 | Blocks all update events |
| upd_src_all | input | 1 | Forced updates also set the flag |
| one_shot | input | 1 | Halt at the first hardware update event |
| dir_down | input | 1 | Edge-mode direction, 1 = down |
| align_mode | input | 2 | 0 edge, 1/2/3 centre variants |
| arl_buf_en | input | 1 | Buffer reload limit until update |
| psc_now | input | 1 | Load prescaler immediately |
| psc_val | input | 16 | Staged prescaler value |
| arl_val | input | 16 | Staged reload limit |
| rep_val | input | 8 | Staged repetition value |
| sw_upd | input | 1 | Software forced update |
| slv_trig | input | 1 | Slave trigger forced update |
| flag_clr | input | 1 | Clears the update flag |
| cnt_out | output | 16 | Counter value |
| cnt_dir | output | 1 | 1 while counting down |
| upd_pulse | output | 1 | One-cycle update event pulse |
| upd_flag | output | 1 | Sticky update flag |

## Verification
A wrong prescaler count or working prescaler shows on `cnt_out` within one prescaled period. A stale reload limit or a bad centre-mode direction bit shows within one counter period: the value goes past its limit, or `cnt_dir` flips at the wrong place. A wrong repetition count shows only at the next update, up to REP+1 wraps later, as a missing or extra `upd_pulse`. The bench therefore keeps periods short and compares every output against its own model on every cycle, so that such slow faults still surface inside each test phase.

// File: rtl/tmr_pkg.sv
// Shared types for the timer time base.
package tmr_pkg;
    // Counter alignment: edge, or centre with wrap at bottom / top / both.
    typedef enum logic [1:0] {
        ALN_EDGE     = 2'd0,
        ALN_CTR_BOT  = 2'd1,
        ALN_CTR_TOP  = 2'd2,
        ALN_CTR_BOTH = 2'd3
    } align_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: produces one counting tick every (working value + 1) running
// cycles. Assumes restart has priority over ticking and that the update
// event input arrives in the same cycle it applies.
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             load_now_i,
    input  logic             ue_i,
    input  logic [PSC_W-1:0] psc_val_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] psc_cnt;
    logic [PSC_W-1:0] psc_act;

    assign tick_o = run_i && !restart_i && (psc_cnt >= psc_act);

    // Working prescaler: immediate or update-time load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            psc_act <= '0;
        else if (load_now_i || ue_i)
            psc_act <= psc_val_i;
    end

    // Divider count: cleared on restart or tick, advances while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            psc_cnt <= '0;
        else if (restart_i || tick_o)
            psc_cnt <= '0;
        else if (run_i)
            psc_cnt <= psc_cnt + 1'b1;
    end

    // R2
    psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(psc_cnt));
endmodule

// File: rtl/tmr_count_core.sv
// Counter core: steps the counter on each tick according to the alignment
// mode and reports qualified wraps. Holds the working reload limit.
// Assumes tick_i is never high together with restart_i.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  align_e           mode_i,
    input  logic             dir_down_i,
    input  logic             arl_buf_i,
    input  logic             ue_i,
    input  logic [CNT_W-1:0] arl_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q, cnt_nx, arl_act;
    logic             dir_q, dir_nx;
    logic             edge_wrap, turn_top, turn_bot;
    logic [1:0]       mode_b;

    assign mode_b = mode_i;

    // Next count and direction for one tick.
    always_comb begin
        cnt_nx    = cnt_q;
        dir_nx    = dir_q;
        edge_wrap = 1'b0;
        turn_top  = 1'b0;
        turn_bot  = 1'b0;
        if (mode_i == ALN_EDGE) begin
            dir_nx = 1'b0;
            if (dir_down_i) begin
                if (cnt_q == '0) begin
                    cnt_nx    = arl_act;
                    edge_wrap = 1'b1;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end else begin
                if (cnt_q >= arl_act) begin
                    cnt_nx    = '0;
                    edge_wrap = 1'b1;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
        end else if (!dir_q) begin
            if (cnt_q >= arl_act) begin
                turn_top = 1'b1;
                dir_nx   = 1'b1;
                cnt_nx   = (arl_act == '0) ? '0 : arl_act - 1'b1;
            end else begin
                cnt_nx = cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == '0) begin
                turn_bot = 1'b1;
                dir_nx   = 1'b0;
                cnt_nx   = (arl_act == '0) ? '0 : CNT_W'(1);
            end else begin
                cnt_nx = cnt_q - 1'b1;
            end
        end
    end

    assign wrap_o = tick_i && (edge_wrap || (turn_top && mode_b[1]) ||
                               (turn_bot && mode_b[0]));

    // Counter and centre direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (restart_i) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (tick_i) begin
            cnt_q <= cnt_nx;
            dir_q <= dir_nx;
        end
    end

    // Working reload limit: follows the input or waits for an update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arl_act <= '1;
        else if (!arl_buf_i || ue_i)
            arl_act <= arl_val_i;
    end

    assign cnt_o = cnt_q;
    assign dir_o = dir_q;

    // R3
    edge_up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_i == ALN_EDGE && !dir_down_i && cnt_q < arl_act)
        |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R4
    edge_dn_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_i == ALN_EDGE && dir_down_i && cnt_q == '0)
        |=> cnt_q == $past(arl_act));

    // R5
    ctr_top_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_i != ALN_EDGE && !dir_q && cnt_q >= arl_act) |=> dir_q);
endmodule

// File: rtl/tmr_update_ctrl.sv
// Update control: repetition gating, update event, pulse, sticky flag and
// one-shot halt. Assumes wrap_i is already qualified by the alignment mode.
module tmr_update_ctrl #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap_i,
    input  logic             restart_i,
    input  logic             upd_dis_i,
    input  logic             upd_src_all_i,
    input  logic             one_shot_i,
    input  logic             cnt_en_i,
    input  logic             flag_clr_i,
    input  logic [REP_W-1:0] rep_val_i,
    output logic             ue_o,
    output logic             halt_o,
    output logic             pulse_o,
    output logic             flag_o
);
    logic [REP_W-1:0] rep_cnt;
    logic             hw_ue, forced_ue;
    logic             halt_q, pulse_q, flag_q;

    assign hw_ue     = wrap_i && (rep_cnt == '0) && !upd_dis_i;
    assign forced_ue = restart_i && !upd_dis_i;
    assign ue_o      = hw_ue || forced_ue;

    // Repetition count: reload at update, count wraps otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rep_cnt <= '0;
        else if (ue_o)
            rep_cnt <= rep_val_i;
        else if (wrap_i && rep_cnt != '0)
            rep_cnt <= rep_cnt - 1'b1;
    end

    // One-shot halt: set by a hardware update, released by disabling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_q <= 1'b0;
        else if (!cnt_en_i)
            halt_q <= 1'b0;
        else if (hw_ue && one_shot_i)
            halt_q <= 1'b1;
    end

    // Update pulse, one cycle after the event edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= ue_o;
    end

    // Sticky flag with source qualification; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hw_ue || (forced_ue && upd_src_all_i))
            flag_q <= 1'b1;
        else if (flag_clr_i)
            flag_q <= 1'b0;
    end

    assign halt_o  = halt_q;
    assign pulse_o = pulse_q;
    assign flag_o  = flag_q;

    // R9
    dis_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_dis_i |=> !pulse_q);

    // R11
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(flag_clr_i));
endmodule

// File: rtl/tmr_timebase.sv
// Timer time base top: ties prescaler, counter core and update control.
// Assumes all inputs are synchronous to clk.
module tmr_timebase
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             upd_dis,
    input  logic             upd_src_all,
    input  logic             one_shot,
    input  logic             dir_down,
    input  logic [1:0]       align_mode,
    input  logic             arl_buf_en,
    input  logic             psc_now,
    input  logic [PSC_W-1:0] psc_val,
    input  logic [CNT_W-1:0] arl_val,
    input  logic [REP_W-1:0] rep_val,
    input  logic             sw_upd,
    input  logic             slv_trig,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_out,
    output logic             cnt_dir,
    output logic             upd_pulse,
    output logic             upd_flag
);
    align_e mode;
    logic   run, restart, tick, wrap, ue, halt, core_dir;

    assign mode    = align_e'(align_mode);
    assign restart = sw_upd || slv_trig;
    assign run     = cnt_en && !halt;

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart),
        .load_now_i(psc_now), .ue_i(ue), .psc_val_i(psc_val), .tick_o(tick)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .restart_i(restart),
        .mode_i(mode), .dir_down_i(dir_down), .arl_buf_i(arl_buf_en),
        .ue_i(ue), .arl_val_i(arl_val), .cnt_o(cnt_out), .dir_o(core_dir),
        .wrap_o(wrap)
    );

    tmr_update_ctrl #(.REP_W(REP_W)) u_upd (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .restart_i(restart),
        .upd_dis_i(upd_dis), .upd_src_all_i(upd_src_all),
        .one_shot_i(one_shot), .cnt_en_i(cnt_en), .flag_clr_i(flag_clr),
        .rep_val_i(rep_val), .ue_o(ue), .halt_o(halt),
        .pulse_o(upd_pulse), .flag_o(upd_flag)
    );

    assign cnt_dir = (mode == ALN_EDGE) ? dir_down : core_dir;

    // R13
    restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_out == '0);
endmodule

// File: tb/sim_tmr_timebase.sv
module sim_tmr_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 0, upd_dis = 0, upd_src_all = 0, one_shot = 0;
    logic        dir_down = 0, arl_buf_en = 0, psc_now = 0;
    logic [1:0]  align_mode = 0;
    logic [15:0] psc_val = 0, arl_val = 0;
    logic [7:0]  rep_val = 0;
    logic        sw_upd = 0, slv_trig = 0, flag_clr = 0;
    logic [15:0] cnt_out;
    logic        cnt_dir, upd_pulse, upd_flag;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_timebase u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .upd_dis(upd_dis),
        .upd_src_all(upd_src_all), .one_shot(one_shot), .dir_down(dir_down),
        .align_mode(align_mode), .arl_buf_en(arl_buf_en), .psc_now(psc_now),
        .psc_val(psc_val), .arl_val(arl_val), .rep_val(rep_val),
        .sw_upd(sw_upd), .slv_trig(slv_trig), .flag_clr(flag_clr),
        .cnt_out(cnt_out), .cnt_dir(cnt_dir), .upd_pulse(upd_pulse),
        .upd_flag(upd_flag)
    );

    // Reference model state, built from the requirements.
    logic [15:0] m_pc, m_pa, m_cnt, m_arl;
    logic [7:0]  m_rep;
    logic        m_dir, m_halt, m_pulse, m_flag;

    always @(posedge clk) begin
        logic run, rs, tick, wrap, hw, ue, top, bot, ew;
        logic [15:0] cn;
        logic dn;
        if (!rst_n) begin
            m_pc = 0; m_pa = 0; m_cnt = 0; m_arl = 16'hFFFF; m_rep = 0;
            m_dir = 0; m_halt = 0; m_pulse = 0; m_flag = 0;
        end else begin
            run  = cnt_en && !m_halt;
            rs   = sw_upd || slv_trig;
            tick = run && !rs && (m_pc >= m_pa);
            cn = m_cnt; dn = m_dir; top = 0; bot = 0; ew = 0;
            if (align_mode == 0) begin
                dn = 0;
                if (dir_down) begin
                    if (m_cnt == 0) begin cn = m_arl; ew = 1; end else cn = m_cnt - 1;
                end else begin
                    if (m_cnt >= m_arl) begin cn = 0; ew = 1; end else cn = m_cnt + 1;
                end
            end else if (!m_dir) begin
                if (m_cnt >= m_arl) begin top = 1; dn = 1; cn = (m_arl == 0) ? 16'd0 : m_arl - 1; end
                else cn = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin bot = 1; dn = 0; cn = (m_arl == 0) ? 16'd0 : 16'd1; end
                else cn = m_cnt - 1;
            end
            wrap = tick && (ew || (top && align_mode[1]) || (bot && align_mode[0]));
            hw   = wrap && (m_rep == 0) && !upd_dis;
            ue   = hw || (rs && !upd_dis);
            if (psc_now || ue) m_pa = psc_val;
            if (rs || tick) m_pc = 0; else if (run) m_pc = m_pc + 1;
            if (rs) begin m_cnt = 0; m_dir = 0; end
            else if (tick) begin m_cnt = cn; m_dir = dn; end
            if (!arl_buf_en || ue) m_arl = arl_val;
            if (ue) m_rep = rep_val; else if (wrap && m_rep != 0) m_rep = m_rep - 1;
            if (!cnt_en) m_halt = 0; else if (hw && one_shot) m_halt = 1;
            m_pulse = ue;
            if (hw || (rs && !upd_dis && upd_src_all)) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cmp_model(string req);
        chk(req, "cnt_out", cnt_out, m_cnt);
        chk(req, "cnt_dir", cnt_dir, (align_mode == 0) ? dir_down : m_dir);
        chk(req, "upd_pulse", upd_pulse, m_pulse);
        chk(req, "upd_flag", upd_flag, m_flag);
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Random phase: knobs give mode, rates (1 in N, 0 = never), fixed bits.
    task automatic phase(string req, int ncyc, int mode, bit dd, int p_rs,
                         int p_dis, int p_off, int p_chg, bit os, int p_clr);
        for (int i = 0; i < ncyc; i++) begin
            cmp_model(req);
            align_mode  = (mode < 0) ? ((i % 97 == 0) ? 2'($urandom_range(1, 3)) : align_mode)
                                     : 2'(mode);
            dir_down    = dd;
            one_shot    = os;
            sw_upd      = (p_rs != 0) && ($urandom_range(0, p_rs - 1) == 0);
            slv_trig    = (p_rs != 0) && ($urandom_range(0, p_rs - 1) == 0);
            upd_dis     = (p_dis != 0) && ($urandom_range(0, p_dis - 1) == 0);
            cnt_en      = !((p_off != 0) && ($urandom_range(0, p_off - 1) == 0));
            flag_clr    = (p_clr != 0) && ($urandom_range(0, p_clr - 1) == 0);
            upd_src_all = 1'($urandom);
            if (p_chg != 0 && $urandom_range(0, p_chg - 1) == 0) begin
                psc_val    = 16'($urandom_range(0, 3));
                arl_val    = 16'($urandom_range(0, 12));
                rep_val    = 8'($urandom_range(0, 4));
                psc_now    = 1'($urandom);
                arl_buf_en = 1'($urandom);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cnt_out", cnt_out, 0);
        chk("R1", "cnt_dir", cnt_dir, 0);
        chk("R1", "upd_pulse", upd_pulse, 0);
        chk("R1", "upd_flag", upd_flag, 0);

        // R2 directed: prescaler 2 gives one step per 3 cycles.
        psc_val = 2; arl_val = 100; psc_now = 0; arl_buf_en = 1; sw_upd = 1;
        @(negedge clk);
        chk("R14", "upd_pulse after forced", upd_pulse, 1);
        chk("R10", "flag with src=0", upd_flag, 0);
        sw_upd = 0; cnt_en = 1;
        edges(9);
        chk("R2", "cnt after 9 cycles", cnt_out, 3);
        chk("R14", "pulse gone", upd_pulse, 0);

        // R12 directed: one-shot with limit 2.
        cnt_en = 0; psc_val = 0; arl_val = 2; rep_val = 0; one_shot = 1; sw_upd = 1;
        @(negedge clk);
        sw_upd = 0; cnt_en = 1;
        edges(2);
        chk("R3", "cnt at limit", cnt_out, 2);
        chk("R10", "flag before wrap", upd_flag, 0);
        edges(1);
        chk("R12", "cnt wrapped", cnt_out, 0);
        chk("R14", "pulse at wrap", upd_pulse, 1);
        chk("R10", "flag hw update", upd_flag, 1);
        edges(5);
        chk("R12", "halted cnt", cnt_out, 0);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        chk("R11", "flag cleared", upd_flag, 0);
        one_shot = 0; cnt_en = 0;
        @(negedge clk);

        // Model-compared random phases.
        phase("R3",  2000, 0, 0, 0,   0, 0,  200, 0, 16);
        phase("R4",  2000, 0, 1, 0,   0, 0,  200, 0, 16);
        phase("R5",  4000, -1, 0, 0,  0, 0,  150, 0, 16);
        phase("R2",  2000, 0, 0, 0,   0, 4,  150, 0, 16);
        phase("R6",  3000, 3, 0, 0,   0, 0,  300, 0, 8);
        phase("R7",  2000, 0, 0, 0,   0, 0,  5,   0, 16);
        phase("R8",  2000, 2, 0, 0,   0, 0,  5,   0, 16);
        phase("R9",  2000, 0, 0, 40,  2, 0,  20,  0, 16);
        phase("R10", 2000, 1, 0, 10,  0, 0,  50,  0, 3);
        phase("R11", 2000, 0, 1, 30,  0, 0,  50,  0, 2);
        phase("R12", 3000, 0, 0, 0,   0, 25, 50,  1, 8);
        phase("R13", 2000, -1, 0, 6,  8, 10, 30,  0, 8);
        phase("R14", 2000, -1, 1, 20, 8, 8,  20,  0, 4);
        cmp_model("R14");

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule